// File: doc/BRIEF.md
# Three-Level Prioritised Interrupt Controller

This block gathers interrupt requests from ten standard sources and a group of seven auxiliary sources, and picks the one request that the processor core should serve next. The standard sources are two external pins, two timer overflow events, a serial port, four further external requests and a watchdog. The auxiliary sources are merged into one shared request. The block raises a request line whenever a qualifying source is waiting. When the core acknowledges, the block captures the winner's vector address, records the winner's priority level as in service, and clears the winner's flag where the source is self-clearing. A return pulse from the core ends the innermost service routine.

There are three levels. The merged auxiliary request always sits on the top level. Each standard source has a priority bit that places it on the middle level or the bottom level. A request can interrupt a running routine only when its level is strictly above every level already in service, so routines nest at most three deep. The external pins can be edge-detected or level-following, and the timer events latch until they are vectored.

Top module: `intc3_top`

## Requirements
- R1: After reset `irq_req` is 0, `irq_vec` is 0x00, no level is in service and all latched flags are clear.
- R2: When `ext_edge[i]`=1, a pin `ext_n[i]` seen high on one clock and low on the next sets a flag for external source i (i=0,1). The flag raises a request from the next cycle and is cleared when that source's vector is taken.
- R3: When `ext_edge[i]`=0, the flag of external source i is the inverted pin, registered once. Taking the vector does not clear it.
- R4: A one-cycle `tmr_set[j]` pulse latches the overflow flag of timer j. The flag stays set until timer j's vector is taken.
- R5: The serial request is `ser_rx | ser_tx`. Taking its vector does not clear it.
- R6: `aux_pending` is the OR of `aux_flag & aux_en`. With `aux_grp_en`=1 it forms a top-level request with vector 0x33, and `glb_en` has no effect on it. With `aux_grp_en`=0 it requests nothing.
- R7: With `glb_en`=0 no standard source raises a request. A standard source also needs its `src_en` bit set.
- R8: A standard source is on the middle level when its `src_hi` bit is 1, and on the bottom level when the bit is 0. The highest pending level wins, whatever the source order.
- R9: Within one level the winner is the first pending source in this order: ext0, timer0, ext1, timer1, serial, auxiliary, ext2, ext3, ext4, ext5, watchdog. `src_en`/`src_hi` bits 0..9 cover the standard sources in this order, with the auxiliary group left out.
- R10: `irq_req` is high only when the winner's level is strictly above every level in service. An acknowledge pushes that level onto the in-service set.
- R11: `irq_ret` removes the highest level in service.
- R12: `irq_vec` is loaded only at an acknowledge while `irq_req` is high. It then holds, whatever the flags do.
- R13: The vectors are ext0 0x03, timer0 0x0B, ext1 0x13, timer1 0x1B, serial 0x23, auxiliary 0x33, ext2 0x43, ext3 0x4B, ext4 0x53, ext5 0x5B and watchdog 0x63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_n | input | 2 | Active-low pins of external sources 0 and 1 |
| ext_edge | input | 2 | 1 = edge detection, 0 = level for external 0/1 |
| tmr_set | input | 2 | Overflow pulses of timers 0 and 1 |
| ser_rx | input | 1 | Serial receive flag |
| ser_tx | input | 1 | Serial transmit flag |
| ext_hi | input | 4 | Request levels of external sources 2..5 |
| wdt_req | input | 1 | Watchdog request level |
| aux_flag | input | 7 | Auxiliary source flags |
| aux_en | input | 7 | Per-source auxiliary enables |
| aux_grp_en | input | 1 | Enable of the merged auxiliary request |
| src_en | input | 10 | Standard source enables, in tie-break order |
| src_hi | input | 10 | Standard source priority bits, in tie-break order |
| glb_en | input | 1 | Global enable of the standard sources |
| irq_ack | input | 1 | Core acknowledge pulse |
| irq_ret | input | 1 | Core return-from-interrupt pulse |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | 8 | Vector captured at the last acknowledge |
| aux_pending | output | 1 | OR of the enabled auxiliary flags |

## Verification
The assertions assume the core pulses `irq_ack` only while `irq_req` is high, never pulses `irq_ret` with nothing in service, and never raises both in one cycle. The in-service count checks rely on these three rules. The bench sends every acknowledge after it has seen the request, pairs each return with an earlier acknowledge, and keeps the two pulses in separate cycles. All inputs change on the falling edge, so the clock edge that counts is never in doubt.

// File: rtl/intc3_pkg.sv
// Package: shared sizes, types and the vector map of the interrupt controller.
// Assumes slot order is the fixed tie-break order with the auxiliary group at slot 5.
package intc3_pkg;
    localparam int NSTD   = 10;             // standard sources
    localparam int NAUX   = 7;              // auxiliary sources
    localparam int NSLOT  = NSTD + 1;       // arbitration slots
    localparam int AUXS   = 5;              // slot of the auxiliary group
    localparam int NLVL   = 3;              // priority levels
    localparam int VEC_W  = 8;
    localparam int LVL_W  = $clog2(NLVL);

    typedef logic [LVL_W-1:0] lvl_t;

    // Vector address of an arbitration slot: 8*index+3, index skipping 5 and 7.
    function automatic logic [VEC_W-1:0] slot_vec(input int s);
        int idx;
        if (s < AUXS)       idx = s;
        else if (s == AUXS) idx = 6;
        else                idx = s + 2;
        return VEC_W'(idx * 8 + 3);
    endfunction
endpackage

// File: rtl/intc3_flags.sv
// Flag capture: edge/level detection of external 0/1, latched timer flags,
// pass-through of serial, external 2..5 and watchdog levels.
// Assumes clr is one-hot or zero and arrives in standard-source order.
module intc3_flags
    import intc3_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      ext_n,
    input  logic [1:0]      ext_edge,
    input  logic [1:0]      tmr_set,
    input  logic            ser_rx,
    input  logic            ser_tx,
    input  logic [3:0]      ext_hi,
    input  logic            wdt_req,
    input  logic [NSTD-1:0] clr,
    output logic [NSTD-1:0] std_flag
);
    logic [1:0] pin_q;
    logic [1:0] ext_fl;
    logic [1:0] tmr_fl;

    // One detector per low external pin and one latch per timer.
    for (genvar i = 0; i < 2; i++) begin : g_ext
        // Remember last pin value and hold the edge or level flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pin_q[i]  <= 1'b1;
                ext_fl[i] <= 1'b0;
            end else begin
                pin_q[i] <= ext_n[i];
                if (!ext_edge[i])
                    ext_fl[i] <= ~ext_n[i];
                else if (pin_q[i] && !ext_n[i])
                    ext_fl[i] <= 1'b1;
                else if (clr[2*i])
                    ext_fl[i] <= 1'b0;
            end
        end

        // Latch a timer overflow until its vector is taken.
        always_ff @(posedge clk) begin
            if (!rst_n)              tmr_fl[i] <= 1'b0;
            else if (tmr_set[i])     tmr_fl[i] <= 1'b1;
            else if (clr[2*i+1])     tmr_fl[i] <= 1'b0;
        end
    end

    // Assemble flags in tie-break order.
    always_comb begin
        std_flag    = '0;
        std_flag[0] = ext_fl[0];
        std_flag[1] = tmr_fl[0];
        std_flag[2] = ext_fl[1];
        std_flag[3] = tmr_fl[1];
        std_flag[4] = ser_rx | ser_tx;
        std_flag[8:5] = ext_hi;
        std_flag[9] = wdt_req;
    end
endmodule

// File: rtl/intc3_arb.sv
// Arbiter: finds the highest pending level, the first slot on it, and whether
// it may preempt the levels already in service.
// Assumes in_svc bit k means level k is being served.
module intc3_arb
    import intc3_pkg::*;
(
    input  logic [NSLOT-1:0]       act,
    input  lvl_t [NSLOT-1:0]       slot_lvl,
    input  logic [NLVL-1:0]        in_svc,
    output logic                   grant_ok,
    output lvl_t                   win_lvl,
    output logic [NSLOT-1:0]       win_oh,
    output logic [VEC_W-1:0]       win_vec
);
    logic [NLVL-1:0]  lvl_any;
    logic [NSLOT-1:0] on_lvl;
    logic             found;

    // Which levels have at least one active slot.
    always_comb begin
        lvl_any = '0;
        for (int s = 0; s < NSLOT; s++)
            if (act[s]) lvl_any[slot_lvl[s]] = 1'b1;
    end

    // Highest populated level.
    always_comb begin
        win_lvl = '0;
        for (int l = 0; l < NLVL; l++)
            if (lvl_any[l]) win_lvl = lvl_t'(l);
    end

    // First active slot on the winning level, and its vector.
    always_comb begin
        found   = 1'b0;
        win_oh  = '0;
        win_vec = '0;
        for (int s = 0; s < NSLOT; s++) begin
            on_lvl[s] = act[s] && (slot_lvl[s] == win_lvl);
            if (on_lvl[s] && !found) begin
                found     = 1'b1;
                win_oh[s] = 1'b1;
                win_vec   = slot_vec(s);
            end
        end
    end

    // Allowed only above every level in service.
    always_comb grant_ok = found && !(|(in_svc >> win_lvl));
endmodule

// File: rtl/intc3_svc.sv
// In-service tracker: one bit per level, set at acknowledge, highest cleared at
// return; also holds the vector captured at acknowledge.
// Assumes ack only with grant_ok, ret only with a level in service.
module intc3_svc
    import intc3_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack,
    input  logic              ret,
    input  logic              grant_ok,
    input  lvl_t              win_lvl,
    input  logic [VEC_W-1:0]  win_vec,
    output logic [NLVL-1:0]   in_svc,
    output logic [VEC_W-1:0]  vec_q
);
    logic [NLVL-1:0] popped;
    logic [NLVL-1:0] nxt;
    logic            take;

    // Drop the highest level in service.
    always_comb begin
        popped = in_svc;
        for (int l = NLVL - 1; l >= 0; l--)
            if (in_svc[l] && (popped == in_svc)) popped[l] = 1'b0;
    end

    // Next in-service set: pop on return, then push on acknowledge.
    always_comb begin
        take = ack && grant_ok;
        nxt  = ret ? popped : in_svc;
        if (take) nxt[win_lvl] = 1'b1;
    end

    // Register the set and capture the vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_svc <= '0;
            vec_q  <= '0;
        end else begin
            in_svc <= nxt;
            if (take) vec_q <= win_vec;
        end
    end
endmodule

// File: rtl/intc3_top.sv
// Top: merges auxiliary flags, gates standard sources, assigns levels, and ties
// flag capture, arbitration and in-service tracking together.
// Assumes the core follows the ack/ret rules stated in the brief.
module intc3_top
    import intc3_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       ext_n,
    input  logic [1:0]       ext_edge,
    input  logic [1:0]       tmr_set,
    input  logic             ser_rx,
    input  logic             ser_tx,
    input  logic [3:0]       ext_hi,
    input  logic             wdt_req,
    input  logic [6:0]       aux_flag,
    input  logic [6:0]       aux_en,
    input  logic             aux_grp_en,
    input  logic [9:0]       src_en,
    input  logic [9:0]       src_hi,
    input  logic             glb_en,
    input  logic             irq_ack,
    input  logic             irq_ret,
    output logic             irq_req,
    output logic [7:0]       irq_vec,
    output logic             aux_pending
);
    logic [NSTD-1:0]  std_flag;
    logic [NSTD-1:0]  std_clr;
    logic [NSLOT-1:0] act;
    lvl_t [NSLOT-1:0] slot_lvl;
    logic [NSLOT-1:0] win_oh;
    lvl_t             win_lvl;
    logic [VEC_W-1:0] win_vec;
    logic             grant_ok;
    logic [NLVL-1:0]  in_svc;

    intc3_flags u_flags (
        .clk(clk), .rst_n(rst_n), .ext_n(ext_n), .ext_edge(ext_edge),
        .tmr_set(tmr_set), .ser_rx(ser_rx), .ser_tx(ser_tx), .ext_hi(ext_hi),
        .wdt_req(wdt_req), .clr(std_clr), .std_flag(std_flag)
    );

    // Merged auxiliary request.
    always_comb aux_pending = |(aux_flag & aux_en);

    // Map standard sources around the auxiliary slot.
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        if (s == AUXS) begin : g_aux
            assign act[s]      = aux_pending && aux_grp_en;
            assign slot_lvl[s] = lvl_t'(NLVL - 1);
        end else begin : g_std
            localparam int K = (s < AUXS) ? s : s - 1;
            assign act[s]      = std_flag[K] && src_en[K] && glb_en;
            assign slot_lvl[s] = src_hi[K] ? lvl_t'(1) : lvl_t'(0);
            assign std_clr[K]  = irq_ack && grant_ok && win_oh[s];
        end
    end

    intc3_arb u_arb (
        .act(act), .slot_lvl(slot_lvl), .in_svc(in_svc), .grant_ok(grant_ok),
        .win_lvl(win_lvl), .win_oh(win_oh), .win_vec(win_vec)
    );

    intc3_svc u_svc (
        .clk(clk), .rst_n(rst_n), .ack(irq_ack), .ret(irq_ret),
        .grant_ok(grant_ok), .win_lvl(win_lvl), .win_vec(win_vec),
        .in_svc(in_svc), .vec_q(irq_vec)
    );

    // Request whenever a winner may preempt.
    always_comb irq_req = grant_ok;
endmodule

// File: rtl/intc3_chk.sv
// Checker: temporal properties of the controller, bound to the top module.
// Assumes ack only while irq_req, ret only with a level in service, never both.
module intc3_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       irq_ack,
    input logic       irq_ret,
    input logic       irq_req,
    input logic [7:0] irq_vec,
    input logic       aux_pending,
    input logic       aux_grp_en,
    input logic [2:0] in_svc
);
    // R6
    aux_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_grp_en && aux_pending && in_svc == 3'b000) |-> irq_req);
    // R10
    top_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_svc[2] |-> !irq_req);
    // R10
    push_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req && !irq_ret) |=>
            ($countones(in_svc) == $countones($past(in_svc)) + 1));
    // R11
    pop_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret && !irq_ack && in_svc != 3'b000) |=>
            ($countones(in_svc) + 1 == $countones($past(in_svc))));
    // R12
    vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_ack |=> $stable(irq_vec));
    // R13
    vec_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req) |=> (irq_vec[2:0] == 3'b011));
endmodule

bind intc3_top intc3_chk u_chk (
    .clk(clk), .rst_n(rst_n), .irq_ack(irq_ack), .irq_ret(irq_ret),
    .irq_req(irq_req), .irq_vec(irq_vec), .aux_pending(aux_pending),
    .aux_grp_en(aux_grp_en), .in_svc(in_svc)
);

// File: tb/intc3_top_tb_top.sv
// Scoreboard bench: the ack task queues the expected vector, a monitor pops and
// compares it after the acknowledge edge; level checks are made directly.
module intc3_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ext_n = 2'b11;
    logic [1:0] ext_edge = 2'b11;
    logic [1:0] tmr_set = 2'b00;
    logic       ser_rx = 1'b0;
    logic       ser_tx = 1'b0;
    logic [3:0] ext_hi = 4'h0;
    logic       wdt_req = 1'b0;
    logic [6:0] aux_flag = 7'h00;
    logic [6:0] aux_en = 7'h00;
    logic       aux_grp_en = 1'b0;
    logic [9:0] src_en = 10'h000;
    logic [9:0] src_hi = 10'h000;
    logic       glb_en = 1'b0;
    logic       irq_ack = 1'b0;
    logic       irq_ret = 1'b0;
    logic       irq_req;
    logic [7:0] irq_vec;
    logic       aux_pending;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    bit         done = 1'b0;

    always #5 clk = ~clk;

    intc3_top dut_i (
        .clk(clk), .rst_n(rst_n), .ext_n(ext_n), .ext_edge(ext_edge),
        .tmr_set(tmr_set), .ser_rx(ser_rx), .ser_tx(ser_tx), .ext_hi(ext_hi),
        .wdt_req(wdt_req), .aux_flag(aux_flag), .aux_en(aux_en),
        .aux_grp_en(aux_grp_en), .src_en(src_en), .src_hi(src_hi),
        .glb_en(glb_en), .irq_ack(irq_ack), .irq_ret(irq_ret),
        .irq_req(irq_req), .irq_vec(irq_vec), .aux_pending(aux_pending)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: queue expected vector and pulse acknowledge.
    task automatic ack(input logic [7:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic ret();
        irq_ret = 1'b1;
        @(negedge clk);
        irq_ret = 1'b0;
    endtask

    // Monitor: compare captured vector after every acknowledge edge.
    initial begin
        forever begin
            @(posedge clk);
            if (irq_ack) begin
                @(negedge clk);
                if (exp_q.size() != 0)
                    chk(irq_vec, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    // Watchdog.
    initial begin
        #200000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        chk({7'b0, irq_req}, 8'h00, "R1 req in reset");
        rst_n = 1'b1;
        tick(1);
        chk({7'b0, irq_req}, 8'h00, "R1 req after reset");
        chk(irq_vec, 8'h00, "R1 vec after reset");

        glb_en = 1'b1; src_en = 10'h3FF; src_hi = 10'h000;
        ext_n[0] = 1'b0; tick(1);
        chk({7'b0, irq_req}, 8'h01, "R2 edge request");
        ack(8'h03, "R13 R2 ext0 vector");
        ret();
        chk({7'b0, irq_req}, 8'h00, "R2 edge flag cleared");
        ext_n[0] = 1'b1; tick(1);

        ext_edge[1] = 1'b0; ext_n[1] = 1'b0; tick(1);
        chk({7'b0, irq_req}, 8'h01, "R3 level request");
        ack(8'h13, "R3 ext1 vector");
        ret();
        chk({7'b0, irq_req}, 8'h01, "R3 level not cleared");
        ack(8'h13, "R3 ext1 again");
        ret();
        ext_n[1] = 1'b1; tick(1);
        chk({7'b0, irq_req}, 8'h00, "R3 level follows pin");

        tmr_set[1] = 1'b1; ser_rx = 1'b1; tick(1);
        tmr_set[1] = 1'b0;
        ack(8'h1B, "R9 R4 timer1 before serial");
        ret();
        ack(8'h23, "R5 serial vector");
        ret();
        chk({7'b0, irq_req}, 8'h01, "R5 serial not cleared");

        src_hi[9] = 1'b1; wdt_req = 1'b1; tick(1);
        ack(8'h63, "R8 watchdog high level wins");
        tmr_set[0] = 1'b1; tick(1); tmr_set[0] = 1'b0;
        chk({7'b0, irq_req}, 8'h00, "R10 lower level blocked");
        aux_flag[3] = 1'b1; aux_en[3] = 1'b1; aux_grp_en = 1'b1; tick(1);
        chk({7'b0, irq_req}, 8'h01, "R10 R6 aux preempts");
        ack(8'h33, "R6 aux vector");
        aux_flag[3] = 1'b0; ext_hi[0] = 1'b1; tick(2);
        chk(irq_vec, 8'h33, "R12 vector holds");
        ext_hi[0] = 1'b0;
        ret();
        chk({7'b0, irq_req}, 8'h00, "R11 middle level still served");
        wdt_req = 1'b0;
        ret();
        ack(8'h0B, "R9 R4 timer0 before serial");
        ret();

        glb_en = 1'b0; tick(1);
        chk({7'b0, irq_req}, 8'h00, "R7 global disable");
        aux_flag[0] = 1'b1; aux_en[0] = 1'b0; tick(1);
        chk({7'b0, aux_pending}, 8'h00, "R6 aux source disabled");
        aux_en[0] = 1'b1; aux_grp_en = 1'b0; tick(1);
        chk({7'b0, aux_pending}, 8'h01, "R6 aux pending");
        chk({7'b0, irq_req}, 8'h00, "R6 group disabled");
        aux_grp_en = 1'b1; tick(1);
        chk({7'b0, irq_req}, 8'h01, "R6 aux ignores global enable");
        ack(8'h33, "R6 aux vector again");
        aux_flag = 7'h00; ser_rx = 1'b0;
        ret();
        tick(2);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule